// File: doc/BRIEF.md
# Receive Burst Protocol Checker

This block watches a deskewed packet receive stream that carries one 16-bit word per cycle. A separate strobe marks each word as either a control word or a data word. The block decodes every control word and follows the burst in progress. It keeps one open-packet bit for each port. When a cross-word rule is broken, it raises a registered single-cycle pulse. The rules cover data outside a burst, start markers that come too close together, bursts that are not a whole multiple of 16 bytes, aborts, non-zero pad bytes, reserved control words, addresses outside the port range, and state transitions that are not allowed. On success it also reports valid start, end and address events.

The block is a passive monitor that sits beside the receive data path. It does not calculate parity, deskew the lanes or buffer any data. Every result is visible one clock after the word that caused it.

Top module: `rx_burst_checker`

## Requirements
- R1: A data word (`rx_dat`=1, `rx_ctl`=0) that arrives while no burst is open pulses `err_no_payload`.
- R2: A start of packet is accepted when a payload control word has bit 12 set and names a port with no open packet. If fewer than 8 data words were counted inside bursts since the previous accepted start, that acceptance also pulses `err_sop_gap`. No start has happened after reset, so the first accepted start never pulses `err_sop_gap`.
- R3: A control word closes the open burst. If its end status (bits 14:13) is 00 and the burst held a number of data words that is not a multiple of 8, `err_len` pulses. The burst closes and the packet stays open.
- R4: A control word with end status 01 that closes a burst pulses `evt_abort` and closes that port's packet.
- R5: A control word with end status 11 closes a burst that held data. If bits 7:0 of the last data word are not zero, `err_pad` pulses. End status 10 makes no pad check.
- R6: A control word with bit 15 clear and bit 12 set is reserved. It pulses `evt_rsvd` and changes no state, so an open burst stays open.
- R7: A payload control word (bit 15 set) with an address in bits 11:4 at or above NUM_PORTS pulses `err_addr` and opens no burst.
- R8: `err_proto` pulses in each of these cases:
  - a start on a port whose packet is already open (the burst still opens);
  - a payload word without a start on a port with no open packet (no burst opens);
  - end status 01, 10 or 11 while no burst is open;
  - end status 10 or 11 closing a burst that held no data word (the packet still closes);
  - `rx_ctl` and `rx_dat` high together (the word is otherwise ignored).
- R9: An accepted start pulses `evt_sop`. End status 10 or 11 closing a burst that held data pulses `evt_eop`. A payload word with a valid address pulses `evt_addr`, with the address on `addr_o`.
- R10: Control word layout: bit 15 payload, bits 14:13 end status (00 none, 01 abort, 10 two bytes valid, 11 one byte valid), bit 12 start, bits 11:4 port address, bits 3:0 parity. The parity bits have no effect.
- R11: Every output is registered and follows the causing word by one clock. Each output lasts one cycle per word. Reset clears all outputs, every open-packet bit, the burst state and the start spacing history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_word | input | 16 | Received word |
| rx_ctl | input | 1 | Word is a control word |
| rx_dat | input | 1 | Word is a data word |
| err_no_payload | output | 1 | Data without an open burst |
| err_sop_gap | output | 1 | Starts closer than 8 data words |
| err_len | output | 1 | Burst not a multiple of 16 bytes |
| evt_abort | output | 1 | Packet ended by abort |
| err_pad | output | 1 | Non-zero pad byte |
| evt_rsvd | output | 1 | Reserved control word seen |
| err_addr | output | 1 | Port address out of range |
| err_proto | output | 1 | Disallowed state transition |
| evt_sop | output | 1 | Start of packet accepted |
| evt_eop | output | 1 | Packet ended normally |
| evt_addr | output | 1 | Valid payload address |
| addr_o | output | 8 | Address of the last valid payload word |

## Verification
The assertions check some properties on every cycle:
- each error pulse traces back to the right kind of word one clock earlier;
- a spacing error appears only together with an accepted start;
- an address error never comes with an address or start event;
- at most one way of closing a burst is reported per word;
- a reserved word leaves the open-packet table unchanged.

Other behaviour needs the bench's scenarios, because it depends on history spread across many words:
- the data-word count at the moment a burst closes;
- the start spacing exactly at the limit;
- the last data word's pad byte;
- close-then-open on the same word;
- state cleared by a reset in the middle of a burst.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    localparam int WORD_W = 16;
    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        END_NONE  = 2'b00,
        END_ABORT = 2'b01,
        END_TWO   = 2'b10,
        END_ONE   = 2'b11
    } end_stat_e;

    typedef struct packed {
        logic              payload;
        end_stat_e         end_stat;
        logic              start;
        logic [ADDR_W-1:0] addr;
        logic [3:0]        parity;
    } ctl_word_t;

    typedef struct packed {
        logic no_payload;
        logic sop_gap;
        logic len;
        logic abort;
        logic pad;
        logic rsvd;
        logic addr_bad;
        logic proto;
        logic sop;
        logic eop;
        logic addr_ok;
    } flags_t;

    function automatic logic is_reserved(ctl_word_t c);
        return !c.payload && c.start;
    endfunction

endpackage

// File: rtl/rxb_decode.sv
module rxb_decode
    import rxb_pkg::*;
#(
    parameter int NUM_PORTS = 16
) (
    input  logic [WORD_W-1:0] word,
    input  logic              ctl,
    input  logic              dat,
    output ctl_word_t         cw,
    output logic              take_ctl,
    output logic              take_dat,
    output logic              both,
    output logic              rsvd,
    output logic              addr_in_range
);
    logic unused_parity;

    assign cw            = ctl_word_t'(word);
    assign take_ctl      = ctl && !dat;
    assign take_dat      = dat && !ctl;
    assign both          = ctl && dat;
    assign rsvd          = is_reserved(cw);
    assign addr_in_range = int'(cw.addr) < NUM_PORTS;
    assign unused_parity = ^cw.parity;
endmodule

// File: rtl/rxb_port_table.sv
module rxb_port_table #(
    parameter int NUM_PORTS = 16,
    parameter int PW        = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_en,
    input  logic [PW-1:0]        set_idx,
    input  logic                 clr_en,
    input  logic [PW-1:0]        clr_idx,
    output logic [NUM_PORTS-1:0] open_o
);
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                open_o[g] <= 1'b0;
            end else if (set_en && set_idx == PW'(g)) begin
                open_o[g] <= 1'b1;
            end else if (clr_en && clr_idx == PW'(g)) begin
                open_o[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rxb_sop_gap.sv
module rxb_sop_gap #(
    parameter int MIN_GAP = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic restart,
    output logic too_close
);
    localparam int GW = $clog2(MIN_GAP + 1);

    logic [GW-1:0] gap_q;

    assign too_close = gap_q < GW'(MIN_GAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= GW'(MIN_GAP);
        end else if (restart) begin
            gap_q <= '0;
        end else if (step && too_close) begin
            gap_q <= gap_q + GW'(1);
        end
    end
endmodule

// File: rtl/rx_burst_checker.sv
module rx_burst_checker
    import rxb_pkg::*;
#(
    parameter int NUM_PORTS   = 16,
    parameter int BURST_WORDS = 8,
    parameter int MIN_GAP     = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] rx_word,
    input  logic        rx_ctl,
    input  logic        rx_dat,
    output logic        err_no_payload,
    output logic        err_sop_gap,
    output logic        err_len,
    output logic        evt_abort,
    output logic        err_pad,
    output logic        evt_rsvd,
    output logic        err_addr,
    output logic        err_proto,
    output logic        evt_sop,
    output logic        evt_eop,
    output logic        evt_addr,
    output logic [7:0]  addr_o
);
    localparam int PW   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam int PADW = 1 << PW;
    localparam int CW   = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;

    ctl_word_t cw;
    logic      take_ctl, take_dat, both, rsvd, addr_in_range;

    logic                 in_burst_q, in_burst_n;
    logic [PW-1:0]        port_q, port_n;
    logic [CW-1:0]        cnt_q, cnt_n;
    logic                 has_data_q, has_data_n;
    logic [7:0]           last_lo_q, last_lo_n;
    logic [ADDR_W-1:0]    addr_q, addr_n;
    flags_t               flags_q, flags_n;

    logic [NUM_PORTS-1:0] port_open;
    logic [PADW-1:0]      open_pad;
    logic                 set_en, clr_en, sop_take, data_step, too_close;
    logic [PW-1:0]        new_idx;
    logic                 open_now;

    rxb_decode #(.NUM_PORTS(NUM_PORTS)) dec_i (
        .word(rx_word), .ctl(rx_ctl), .dat(rx_dat), .cw(cw),
        .take_ctl(take_ctl), .take_dat(take_dat), .both(both),
        .rsvd(rsvd), .addr_in_range(addr_in_range)
    );

    rxb_port_table #(.NUM_PORTS(NUM_PORTS), .PW(PW)) tbl_i (
        .clk(clk), .rst(rst),
        .set_en(set_en), .set_idx(new_idx),
        .clr_en(clr_en), .clr_idx(port_q),
        .open_o(port_open)
    );

    rxb_sop_gap #(.MIN_GAP(MIN_GAP)) gap_i (
        .clk(clk), .rst(rst), .step(data_step), .restart(sop_take),
        .too_close(too_close)
    );

    assign open_pad = PADW'(port_open);
    assign new_idx  = cw.addr[PW-1:0];

    always_comb begin
        flags_n    = '0;
        in_burst_n = in_burst_q;
        port_n     = port_q;
        cnt_n      = cnt_q;
        has_data_n = has_data_q;
        last_lo_n  = last_lo_q;
        addr_n     = addr_q;
        set_en     = 1'b0;
        clr_en     = 1'b0;
        sop_take   = 1'b0;
        data_step  = 1'b0;
        open_now   = 1'b0;

        if (both) begin
            flags_n.proto = 1'b1;
        end else if (take_dat) begin
            if (!in_burst_q) begin
                flags_n.no_payload = 1'b1;
            end else begin
                cnt_n      = cnt_q + CW'(1);
                has_data_n = 1'b1;
                last_lo_n  = rx_word[7:0];
                data_step  = 1'b1;
            end
        end else if (take_ctl) begin
            if (rsvd) begin
                flags_n.rsvd = 1'b1;
            end else begin
                // close the burst in progress first
                if (in_burst_q) begin
                    case (cw.end_stat)
                        END_NONE: begin
                            if (cnt_q != '0) flags_n.len = 1'b1;
                        end
                        END_ABORT: begin
                            flags_n.abort = 1'b1;
                            clr_en        = 1'b1;
                        end
                        default: begin
                            clr_en = 1'b1;
                            if (!has_data_q) begin
                                flags_n.proto = 1'b1;
                            end else begin
                                flags_n.eop = 1'b1;
                                if (cw.end_stat == END_ONE && last_lo_q != 8'h00)
                                    flags_n.pad = 1'b1;
                            end
                        end
                    endcase
                end else if (cw.end_stat != END_NONE) begin
                    flags_n.proto = 1'b1;
                end
                in_burst_n = 1'b0;

                // then open the next one
                if (cw.payload) begin
                    if (!addr_in_range) begin
                        flags_n.addr_bad = 1'b1;
                    end else begin
                        flags_n.addr_ok = 1'b1;
                        addr_n          = cw.addr;
                        open_now        = open_pad[new_idx] &&
                                          !(clr_en && port_q == new_idx);
                        if (cw.start) begin
                            if (open_now) begin
                                flags_n.proto = 1'b1;
                            end else begin
                                flags_n.sop     = 1'b1;
                                flags_n.sop_gap = too_close;
                                set_en          = 1'b1;
                                sop_take        = 1'b1;
                            end
                        end else if (!open_now) begin
                            flags_n.proto = 1'b1;
                        end
                        if (cw.start || open_now) begin
                            in_burst_n = 1'b1;
                            port_n     = new_idx;
                            cnt_n      = '0;
                            has_data_n = 1'b0;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_burst_q <= 1'b0;
            port_q     <= '0;
            cnt_q      <= '0;
            has_data_q <= 1'b0;
            last_lo_q  <= '0;
            addr_q     <= '0;
            flags_q    <= '0;
        end else begin
            in_burst_q <= in_burst_n;
            port_q     <= port_n;
            cnt_q      <= cnt_n;
            has_data_q <= has_data_n;
            last_lo_q  <= last_lo_n;
            addr_q     <= addr_n;
            flags_q    <= flags_n;
        end
    end

    assign err_no_payload = flags_q.no_payload;
    assign err_sop_gap    = flags_q.sop_gap;
    assign err_len        = flags_q.len;
    assign evt_abort      = flags_q.abort;
    assign err_pad        = flags_q.pad;
    assign evt_rsvd       = flags_q.rsvd;
    assign err_addr       = flags_q.addr_bad;
    assign err_proto      = flags_q.proto;
    assign evt_sop        = flags_q.sop;
    assign evt_eop        = flags_q.eop;
    assign evt_addr       = flags_q.addr_ok;
    assign addr_o         = addr_q;
endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
    parameter int NUM_PORTS = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic [15:0]          rx_word,
    input logic                 rx_ctl,
    input logic                 rx_dat,
    input logic                 err_no_payload,
    input logic                 err_sop_gap,
    input logic                 err_len,
    input logic                 evt_abort,
    input logic                 err_pad,
    input logic                 err_addr,
    input logic                 evt_sop,
    input logic                 evt_eop,
    input logic                 evt_addr,
    input logic [NUM_PORTS-1:0] port_open
);
    p_nopay_src_r1: assert property (@(posedge clk) disable iff (rst)
        err_no_payload |-> $past(rx_dat && !rx_ctl));

    p_gap_with_sop_r2: assert property (@(posedge clk) disable iff (rst)
        err_sop_gap |-> evt_sop);

    p_len_src_r3: assert property (@(posedge clk) disable iff (rst)
        err_len |-> $past(rx_ctl && !rx_dat && rx_word[14:13] == 2'b00));

    p_abort_src_r4: assert property (@(posedge clk) disable iff (rst)
        evt_abort |-> $past(rx_ctl && !rx_dat && rx_word[14:13] == 2'b01));

    p_close_excl_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt_eop, evt_abort, err_len}));

    p_pad_src_r5: assert property (@(posedge clk) disable iff (rst)
        err_pad |-> (evt_eop && $past(rx_word[14:13] == 2'b11)));

    p_rsvd_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_ctl && !rx_dat && !rx_word[15] && rx_word[12]) |=> $stable(port_open));

    p_addr_excl_r7: assert property (@(posedge clk) disable iff (rst)
        err_addr |-> (!evt_addr && !evt_sop));
endmodule

bind rx_burst_checker rxb_checker #(.NUM_PORTS(NUM_PORTS)) chk_i (
    .clk(clk), .rst(rst), .rx_word(rx_word), .rx_ctl(rx_ctl), .rx_dat(rx_dat),
    .err_no_payload(err_no_payload), .err_sop_gap(err_sop_gap),
    .err_len(err_len), .evt_abort(evt_abort), .err_pad(err_pad),
    .err_addr(err_addr), .evt_sop(evt_sop), .evt_eop(evt_eop),
    .evt_addr(evt_addr), .port_open(port_open)
);

// File: tb/rx_burst_checker_tb.sv
module rx_burst_checker_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] rx_word = '0;
    logic        rx_ctl = 1'b0;
    logic        rx_dat = 1'b0;
    logic        err_no_payload, err_sop_gap, err_len, evt_abort, err_pad;
    logic        evt_rsvd, err_addr, err_proto, evt_sop, evt_eop, evt_addr;
    logic [7:0]  addr_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rx_burst_checker #(.NUM_PORTS(16), .BURST_WORDS(8), .MIN_GAP(8)) dut_i (
        .clk(clk), .rst(rst), .rx_word(rx_word), .rx_ctl(rx_ctl), .rx_dat(rx_dat),
        .err_no_payload(err_no_payload), .err_sop_gap(err_sop_gap),
        .err_len(err_len), .evt_abort(evt_abort), .err_pad(err_pad),
        .evt_rsvd(evt_rsvd), .err_addr(err_addr), .err_proto(err_proto),
        .evt_sop(evt_sop), .evt_eop(evt_eop), .evt_addr(evt_addr),
        .addr_o(addr_o)
    );

    // expected flag order, msb first:
    // no_payload sop_gap len abort pad rsvd addr proto sop eop addr_valid
    typedef struct packed {
        logic        c;
        logic        d;
        logic [15:0] w;
        logic [10:0] e;
    } vec_t;

    localparam int NV = 45;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 16'h1234, 11'b10000000000},  //  0 R1 data, no burst
        '{1'b1, 1'b0, 16'h9020, 11'b00000000101},  //  1 R9 start port 2
        '{1'b0, 1'b1, 16'hAB00, 11'b00000000000},
        '{1'b0, 1'b1, 16'hAB00, 11'b00000000000},
        '{1'b0, 1'b1, 16'hAB00, 11'b00000000000},
        '{1'b0, 1'b0, 16'h0000, 11'b00000000000},  //  5 idle
        '{1'b1, 1'b0, 16'h0000, 11'b00100000000},  //  6 R3 3 words, no end
        '{1'b0, 1'b1, 16'h5555, 11'b10000000000},  //  7 R1 burst closed
        '{1'b1, 1'b0, 16'h8020, 11'b00000000001},  //  8 continue port 2
        '{1'b0, 1'b1, 16'hAB00, 11'b00000000000},
        '{1'b0, 1'b1, 16'hAB00, 11'b00000000000},
        '{1'b0, 1'b1, 16'hAB00, 11'b00000000000},
        '{1'b0, 1'b1, 16'hAB00, 11'b00000000000},
        '{1'b0, 1'b1, 16'hCD01, 11'b00000000000},
        '{1'b1, 1'b0, 16'h6000, 11'b00001000010},  // 14 R5 one byte, pad 01
        '{1'b1, 1'b0, 16'h9020, 11'b00000000101},  // 15 R2 gap exactly 8
        '{1'b0, 1'b1, 16'h1100, 11'b00000000000},
        '{1'b1, 1'b0, 16'hD030, 11'b01000000111},  // 17 R2 close + start port 3
        '{1'b0, 1'b1, 16'h0000, 11'b00000000000},
        '{1'b1, 1'b0, 16'h1000, 11'b00000100000},  // 19 R6 reserved
        '{1'b0, 1'b1, 16'h00FF, 11'b00000000000},  // 20 R6 burst still open
        '{1'b1, 1'b0, 16'h2000, 11'b00010000000},  // 21 R4 abort
        '{1'b1, 1'b0, 16'h8030, 11'b00000001001},  // 22 R8 no start, closed port
        '{1'b1, 1'b0, 16'h8100, 11'b00000010000},  // 23 R7 address 16
        '{1'b0, 1'b1, 16'h0000, 11'b10000000000},  // 24 R7 no burst opened
        '{1'b1, 1'b0, 16'h9050, 11'b01000000101},  // 25 R2 gap 2
        '{1'b1, 1'b0, 16'h9050, 11'b00000001001},  // 26 R8 start on open port
        '{1'b1, 1'b1, 16'h0000, 11'b00000001000},  // 27 R8 both strobes
        '{1'b1, 1'b0, 16'h4000, 11'b00000001000},  // 28 R8 end with no data
        '{1'b1, 1'b0, 16'h4000, 11'b00000001000},  // 29 R8 end, no burst
        '{1'b1, 1'b0, 16'h9FF5, 11'b00000010000},  // 30 R7 address 255
        '{1'b1, 1'b0, 16'h905A, 11'b01000000101},  // 31 R10 parity ignored
        '{1'b0, 1'b1, 16'h0102, 11'b00000000000},
        '{1'b0, 1'b1, 16'h0304, 11'b00000000000},
        '{1'b0, 1'b1, 16'h0506, 11'b00000000000},
        '{1'b0, 1'b1, 16'h0708, 11'b00000000000},
        '{1'b0, 1'b1, 16'h090A, 11'b00000000000},
        '{1'b0, 1'b1, 16'h0B0C, 11'b00000000000},
        '{1'b0, 1'b1, 16'h0D0E, 11'b00000000000},
        '{1'b0, 1'b1, 16'h0F10, 11'b00000000000},
        '{1'b1, 1'b0, 16'h0000, 11'b00000000000},  // 40 R3 8 words, no error
        '{1'b1, 1'b0, 16'h8050, 11'b00000000001},
        '{1'b0, 1'b1, 16'h12FF, 11'b00000000000},
        '{1'b1, 1'b0, 16'h4000, 11'b00000000010},  // 43 R5 two bytes, no pad check
        '{1'b1, 1'b0, 16'h9050, 11'b00000000101}   // 44 R2 gap 9
    };

    function automatic string req_of(int bitpos);
        case (bitpos)
            10: return "R1";
            9:  return "R2";
            8:  return "R3";
            7:  return "R4";
            6:  return "R5";
            5:  return "R6";
            4:  return "R7";
            3:  return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check_out(input logic [10:0] exp, input logic [7:0] exp_addr,
                             input string what);
        logic [10:0] act;
        string       tag;
        act = {err_no_payload, err_sop_gap, err_len, evt_abort, err_pad,
               evt_rsvd, err_addr, err_proto, evt_sop, evt_eop, evt_addr};
        checks++;
        if (act !== exp) begin
            tag = "R11";
            for (int b = 0; b < 11; b++) if (act[b] !== exp[b]) tag = req_of(b);
            failures++;
            $display("FAIL %s %s flags act=%b exp=%b", tag, what, act, exp);
        end else if (exp[0] && addr_o !== exp_addr) begin
            failures++;
            $display("FAIL R9 %s addr_o act=%h exp=%h", what, addr_o, exp_addr);
        end
    endtask

    task automatic drive(input logic c, input logic d, input logic [15:0] w);
        rx_ctl  = c;
        rx_dat  = d;
        rx_word = w;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_out(11'b0, 8'h00, "R11 reset state");

        for (int i = 0; i <= NV; i++) begin
            if (i > 0) begin
                @(negedge clk);
                check_out(VEC[i-1].e, VEC[i-1].w[11:4], $sformatf("vector %0d", i - 1));
            end
            if (i < NV) drive(VEC[i].c, VEC[i].d, VEC[i].w);
            else        drive(1'b0, 1'b0, 16'h0000);
        end

        // R11 pulses end after one cycle
        @(negedge clk);
        check_out(11'b0, 8'h00, "R11 pulse cleared after idle");

        // R11 reset in the middle of an open burst on port 5
        rst = 1'b1;
        @(negedge clk);
        check_out(11'b0, 8'h00, "R11 outputs during reset");
        rst = 1'b0;
        drive(1'b0, 1'b1, 16'hAAAA);
        @(negedge clk);
        check_out(11'b10000000000, 8'h00, "R11 burst cleared by reset (R1)");
        drive(1'b1, 1'b0, 16'h9050);
        @(negedge clk);
        check_out(11'b00000000101, 8'h05, "R11 port table and spacing cleared (R2 R8)");
        drive(1'b0, 1'b0, 16'h0000);
        @(negedge clk);
        check_out(11'b0, 8'h05, "R11 idle after start");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R11 watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule